// File: doc/BRIEF.md
# Capture/Compare Channel with Toggle Output

This block is one channel of a timer array. All channels of the array share one free-running 16-bit time base, and each channel reads its count. Software programs a 7-bit mode word and a 16-bit channel register, which it writes as two bytes. The mode word picks the work the channel does. It can latch the time base when a chosen edge arrives on its pin, or raise a flag when the time base reaches the register value. It can also invert its output pin on each such match.

The channel sends a one-cycle event strobe on every capture or match. It keeps a sticky flag that software clears, and it asserts an interrupt request while the flag is set and interrupts are enabled. The pin input passes through a two-stage synchronizer before the edge detector sees it.

A small state machine tracks the operating state. There are four states. ST_OFF means neither capture nor compare is active. ST_CAPTURE means at least one capture edge is enabled. ST_COMPARE means the comparator is running. ST_ARMING means a low-byte write has suspended the comparator and the channel is waiting for the high byte.

The transitions are as follows. A mode write from any state goes to the state that the new mode word decodes to. A low-byte write goes from ST_COMPARE to ST_ARMING. A high-byte write without a low-byte write in the same cycle goes from ST_ARMING or ST_OFF to ST_COMPARE. Byte writes leave ST_CAPTURE unchanged. Any cycle with no write keeps the current state.

Top module: `ccp_channel`

## Requirements
- R1: After reset, the mode word and the channel register read 0, the output pin is high, and the flag, the event strobe and the interrupt request are low.
- R2: A low-byte write loads register bits 7:0 and a high-byte write loads bits 15:8, at the next clock edge. A byte write takes priority over a capture in the same cycle.
- R3: A low-byte write clears mode bit 6 (comparator enable) and a high-byte write sets it. A full mode write in the same cycle takes priority, and a low-byte write takes priority over a high-byte write.
- R4: When a capture edge is enabled, a pin transition copies the time base into the channel register and sets the flag. The copy uses the time base value present at the third rising clock edge after the pin changes.
- R5: Mode bit 5 selects rising-edge capture and bit 4 selects falling-edge capture. With both bits set, either direction captures. A transition in a direction that is not selected changes nothing.
- R6: With mode bits 6 and 3 set and both capture bits clear, the flag sets when the time base first equals the channel register.
- R7: A match is reported once per arrival at the register value. If the time base holds at the matching value, the match is not reported again.
- R8: With mode bits 6, 3 and 2 all set, the output pin inverts on every match. Setting bit 2 without bit 3 leaves the pin unchanged.
- R9: When either capture bit is set, the comparator is inactive. Equality then produces no flag and no toggle.
- R10: The interrupt request is high exactly when the flag is set and mode bit 0 is 1.
- R11: The flag stays set until a clear pulse arrives. An event in the same cycle as a clear pulse leaves the flag set.
- R12: Each capture or match produces an event strobe that lasts exactly one cycle, in the cycle after the clock edge that detected it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase | input | 16 | Shared time base count |
| mode_we | input | 1 | Load mode word from mode_din |
| mode_din | input | 7 | New mode word |
| lo_we | input | 1 | Write low byte of channel register |
| hi_we | input | 1 | Write high byte of channel register |
| byte_din | input | 8 | Byte data for lo_we / hi_we |
| flag_clr | input | 1 | Clear the channel flag |
| pin_in | input | 1 | Asynchronous pin sample |
| pin_out | output | 1 | Output pin level |
| mode_q | output | 7 | Current mode word |
| cc_val | output | 16 | Current channel register |
| event_stb | output | 1 | One-cycle capture/match strobe |
| flag | output | 1 | Sticky channel flag |
| irq | output | 1 | Gated interrupt request |

## Verification
Mode and byte writes show on mode_q and cc_val one clock edge after they are applied. A match shows on event_stb, flag and pin_out one edge after the edge at which the time base first equals the register. A capture needs two synchronizer edges plus the capture edge, so its result appears three edges after the pin moves. The bench drives every input just after the falling clock edge. It advances a behavioural model at each rising edge and compares all outputs at the following falling edge, so each result is checked in the cycle it is due. For the capture tests the time base is held still, so the expected captured value is known regardless of latency.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int MODE_W     = 7;
    localparam int B_IRQ_EN   = 0;
    localparam int B_PWM_SEL  = 1;
    localparam int B_TOGGLE   = 2;
    localparam int B_MATCH    = 3;
    localparam int B_CAP_FALL = 4;
    localparam int B_CAP_RISE = 5;
    localparam int B_CMP_EN   = 6;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CAPTURE,
        ST_COMPARE,
        ST_ARMING
    } ccp_state_e;

    function automatic ccp_state_e decode_mode(input logic [MODE_W-1:0] m);
        if (m[B_CAP_RISE] || m[B_CAP_FALL])
            return ST_CAPTURE;
        else if (m[B_CMP_EN])
            return ST_COMPARE;
        else
            return ST_OFF;
    endfunction
endpackage

// File: rtl/ccp_pin_sync.sv
module ccp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[LAST-1:0], pin_in};
    end

    // chain[LAST-1] is the synchronized level, chain[LAST] the previous one
    assign rise = chain[LAST-1] & ~chain[LAST];
    assign fall = ~chain[LAST-1] & chain[LAST];
endmodule

// File: rtl/ccp_regbank.sv
module ccp_regbank
    import ccp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_din,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [CNT_W/2-1:0] byte_din,
    input  logic              cap_fire,
    input  logic [CNT_W-1:0]  tbase,
    output logic [MODE_W-1:0] mode_q,
    output logic [CNT_W-1:0]  cc_val
);
    localparam int HALF = CNT_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= mode_din;
        end else if (lo_we) begin
            mode_q[B_CMP_EN] <= 1'b0;
        end else if (hi_we) begin
            mode_q[B_CMP_EN] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_val <= '0;
        end else if (lo_we || hi_we) begin
            if (lo_we) cc_val[HALF-1:0]     <= byte_din;
            if (hi_we) cc_val[CNT_W-1:HALF] <= byte_din;
        end else if (cap_fire) begin
            cc_val <= tbase;
        end
    end
endmodule

// File: rtl/ccp_cmp_detect.sv
module ccp_cmp_detect #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] tbase,
    input  logic [CNT_W-1:0] cc_val,
    output logic             hit
);
    logic eq_now;
    logic eq_q;

    assign eq_now = cmp_en && (tbase == cc_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            eq_q <= 1'b0;
        else
            eq_q <= eq_now;
    end

    assign hit = eq_now & ~eq_q;
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    tbase,
    input  logic                mode_we,
    input  logic [MODE_W-1:0]   mode_din,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [CNT_W/2-1:0]  byte_din,
    input  logic                flag_clr,
    input  logic                pin_in,
    output logic                pin_out,
    output logic [MODE_W-1:0]   mode_q,
    output logic [CNT_W-1:0]    cc_val,
    output logic                event_stb,
    output logic                flag,
    output logic                irq
);
    ccp_state_e state_q;
    ccp_state_e state_d;

    logic rise;
    logic fall;
    logic cap_fire;
    logic hit;
    logic match_ev;
    logic toggle_now;
    logic event_d;

    ccp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(pin_in),
        .rise  (rise),
        .fall  (fall)
    );

    ccp_regbank #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_we (mode_we),
        .mode_din(mode_din),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .byte_din(byte_din),
        .cap_fire(cap_fire),
        .tbase   (tbase),
        .mode_q  (mode_q),
        .cc_val  (cc_val)
    );

    ccp_cmp_detect #(.CNT_W(CNT_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .cmp_en(state_q == ST_COMPARE),
        .tbase (tbase),
        .cc_val(cc_val),
        .hit   (hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode_we)                 state_d = decode_mode(mode_din);
                else if (hi_we && !lo_we)    state_d = ST_COMPARE;
            end
            ST_CAPTURE: begin
                if (mode_we)                 state_d = decode_mode(mode_din);
            end
            ST_COMPARE: begin
                if (mode_we)                 state_d = decode_mode(mode_din);
                else if (lo_we)              state_d = ST_ARMING;
            end
            ST_ARMING: begin
                if (mode_we)                 state_d = decode_mode(mode_din);
                else if (hi_we && !lo_we)    state_d = ST_COMPARE;
            end
            default:                         state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    assign cap_fire   = (state_q == ST_CAPTURE) &&
                        ((rise && mode_q[B_CAP_RISE]) || (fall && mode_q[B_CAP_FALL]));
    assign match_ev   = hit && mode_q[B_MATCH];
    assign toggle_now = match_ev && mode_q[B_TOGGLE];
    assign event_d    = cap_fire || match_ev;

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_stb <= 1'b0;
            flag      <= 1'b0;
            pin_out   <= 1'b1;
        end else begin
            event_stb <= event_d;
            if (event_d)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
            if (toggle_now)
                pin_out <= ~pin_out;
        end
    end

    assign irq = flag & mode_q[B_IRQ_EN];
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk
    import ccp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lo_we,
    input logic              hi_we,
    input logic              pin_out,
    input logic [MODE_W-1:0] mode_q,
    input logic [CNT_W-1:0]  cc_val,
    input logic              event_stb,
    input logic              flag,
    input logic              irq,
    input ccp_state_e        state_q
);
    // R8: a toggle of the pin always comes with a match strobe
    assert_toggle_has_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out != $past(pin_out)) |-> event_stb);

    // R12: every strobe leaves the flag set
    assert_strobe_sets_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        event_stb |-> flag);

    // R10: request only with flag and enable
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && mode_q[B_IRQ_EN]));

    // R4: register moves without a byte write only through a capture
    assert_capture_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cc_val != $past(cc_val)) && !$past(lo_we) && !$past(hi_we)) |-> event_stb);

    // R9: comparator state never coexists with capture bits
    assert_compare_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE) |-> (mode_q[B_CMP_EN] && !mode_q[B_CAP_RISE] && !mode_q[B_CAP_FALL]));

    // R3: suspended comparator waits with its enable cleared
    assert_arming_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMING) |-> !mode_q[B_CMP_EN]);
endmodule

bind ccp_channel ccp_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_we    (lo_we),
    .hi_we    (hi_we),
    .pin_out  (pin_out),
    .mode_q   (mode_q),
    .cc_val   (cc_val),
    .event_stb(event_stb),
    .flag     (flag),
    .irq      (irq),
    .state_q  (state_q)
);

// File: tb/ccp_channel_test.sv
`timescale 1ns/100ps
module ccp_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tbase = '0;
    logic        mode_we = 1'b0;
    logic [6:0]  mode_din = '0;
    logic        lo_we = 1'b0;
    logic        hi_we = 1'b0;
    logic [7:0]  byte_din = '0;
    logic        flag_clr = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic [6:0]  mode_q;
    logic [15:0] cc_val;
    logic        event_stb;
    logic        flag;
    logic        irq;

    ccp_channel uut (
        .clk(clk), .rst_n(rst_n), .tbase(tbase), .mode_we(mode_we), .mode_din(mode_din),
        .lo_we(lo_we), .hi_we(hi_we), .byte_din(byte_din), .flag_clr(flag_clr),
        .pin_in(pin_in), .pin_out(pin_out), .mode_q(mode_q), .cc_val(cc_val),
        .event_stb(event_stb), .flag(flag), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    chk_on = 1'b0;
    bit    run = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [6:0]  m_mode;
    logic [15:0] m_val;
    logic        m_flag, m_ev, m_pout, m_eqp;
    logic [2:0]  m_pin;   // [0] newest sample

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = '0; m_val = '0; m_flag = 0; m_ev = 0; m_pout = 1; m_eqp = 0; m_pin = '0;
        end else begin
            bit capb, up, dn, cap, cmp, eq, hitv, ev, tg;
            capb = m_mode[5] || m_mode[4];
            up   = m_pin[1] && !m_pin[2];
            dn   = !m_pin[1] && m_pin[2];
            cap  = capb && ((up && m_mode[5]) || (dn && m_mode[4]));
            cmp  = m_mode[6] && !capb;
            eq   = cmp && (tbase == m_val);
            hitv = eq && !m_eqp;
            ev   = cap || (hitv && m_mode[3]);
            tg   = hitv && m_mode[3] && m_mode[2];
            if (mode_we) m_mode = mode_din;
            else if (lo_we) m_mode[6] = 1'b0;
            else if (hi_we) m_mode[6] = 1'b1;
            if (lo_we || hi_we) begin
                if (lo_we) m_val[7:0] = byte_din;
                if (hi_we) m_val[15:8] = byte_din;
            end else if (cap) m_val = tbase;
            if (ev) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            m_ev = ev;
            if (tg) m_pout = ~m_pout;
            m_eqp = eq;
            m_pin = {m_pin[1:0], pin_in};
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk(cur_req, "pin_out", {31'd0, pin_out}, {31'd0, m_pout});
            chk(cur_req, "mode_q", {25'd0, mode_q}, {25'd0, m_mode});
            chk(cur_req, "cc_val", {16'd0, cc_val}, {16'd0, m_val});
            chk(cur_req, "event_stb", {31'd0, event_stb}, {31'd0, m_ev});
            chk(cur_req, "flag", {31'd0, flag}, {31'd0, m_flag});
            chk(cur_req, "irq", {31'd0, irq}, {31'd0, m_flag & m_mode[0]});
        end
    end

    always @(negedge clk) begin
        #1;
        if (run) tbase = tbase + 16'd1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_mode(input logic [6:0] v);
        mode_we = 1; mode_din = v; cyc(); mode_we = 0;
    endtask

    task automatic wr_lo(input logic [7:0] v);
        lo_we = 1; byte_din = v; cyc(); lo_we = 0;
    endtask

    task automatic wr_hi(input logic [7:0] v);
        hi_we = 1; byte_din = v; cyc(); hi_we = 0;
    endtask

    task automatic clr_flag();
        flag_clr = 1; cyc(); flag_clr = 0;
    endtask

    initial begin
        logic p0;
        int   pulses;
        cyc(3);
        rst_n = 1;
        chk_on = 1;
        @(negedge clk);
        // R1 reset values
        chk("R1", "pin_out", {31'd0, pin_out}, 32'd1);
        chk("R1", "flag", {31'd0, flag}, 32'd0);
        chk("R1", "irq", {31'd0, irq}, 32'd0);
        chk("R1", "cc_val", {16'd0, cc_val}, 32'd0);
        chk("R1", "mode_q", {25'd0, mode_q}, 32'd0);
        #1;

        // R2 / R3 byte writes and comparator gating
        cur_req = "R3";
        wr_mode(7'h48);
        wr_lo(8'h34);
        @(negedge clk);
        chk("R3", "cmp enable after low byte", {31'd0, mode_q[6]}, 32'd0);
        #1;
        cur_req = "R2";
        wr_hi(8'h12);
        @(negedge clk);
        chk("R2", "cc_val after byte writes", {16'd0, cc_val}, 32'h1234);
        chk("R3", "cmp enable after high byte", {31'd0, mode_q[6]}, 32'd1);
        #1;

        // R6 software timer
        cur_req = "R6";
        wr_mode(7'h49);
        tbase = 16'h1220; run = 1;
        cyc(30);
        run = 0;
        @(negedge clk);
        chk("R6", "flag after match", {31'd0, flag}, 32'd1);
        cur_req = "R10";
        chk("R10", "irq enabled", {31'd0, irq}, 32'd1);
        #1;
        wr_mode(7'h48);
        @(negedge clk);
        chk("R10", "irq masked", {31'd0, irq}, 32'd0);
        #1;

        // R11 clear and set-wins
        cur_req = "R11";
        clr_flag();
        @(negedge clk);
        chk("R11", "flag cleared", {31'd0, flag}, 32'd0);
        #1;
        flag_clr = 1; tbase = 16'h1230; run = 1;
        cyc(12);
        run = 0; flag_clr = 0;
        cyc();

        // R7 hold at matching value
        cur_req = "R7";
        tbase = 16'h1000; cyc();
        tbase = 16'h1234;
        pulses = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (event_stb) pulses++;
            #1;
        end
        chk("R7", "strobes while held", pulses, 32'd1);

        // R8 toggle on match; R12 strobe width
        cur_req = "R8";
        wr_mode(7'h4C);
        tbase = 16'h1233; cyc(2);
        p0 = pin_out;
        for (int i = 0; i < 6; i++) begin
            tbase = (i % 2 == 0) ? 16'h1234 : 16'h1233;
            cyc();
        end
        tbase = 16'h1233; cyc();
        @(negedge clk);
        chk("R8", "pin after three matches", {31'd0, pin_out}, {31'd0, ~p0});
        #1;
        cur_req = "R12";
        tbase = 16'h1234;
        @(negedge clk);
        chk("R12", "strobe high", {31'd0, event_stb}, 32'd1);
        @(negedge clk);
        chk("R12", "strobe low", {31'd0, event_stb}, 32'd0);
        #1;
        cur_req = "R8";
        wr_mode(7'h44);
        tbase = 16'h1233; cyc();
        p0 = pin_out;
        for (int i = 0; i < 6; i++) begin
            tbase = (i % 2 == 0) ? 16'h1234 : 16'h1233;
            cyc();
        end
        @(negedge clk);
        chk("R8", "no toggle without match bit", {31'd0, pin_out}, {31'd0, p0});
        #1;

        // R4 rising capture
        cur_req = "R4";
        wr_mode(7'h20);
        clr_flag();
        tbase = 16'h0ABC; pin_in = 1;
        cyc(4);
        @(negedge clk);
        chk("R4", "captured value", {16'd0, cc_val}, 32'h0ABC);
        chk("R4", "flag after capture", {31'd0, flag}, 32'd1);
        #1;

        // R5 edge selection
        cur_req = "R5";
        pin_in = 0; cyc(4);
        wr_mode(7'h10);
        clr_flag();
        tbase = 16'h0BCD; pin_in = 1; cyc(4);
        @(negedge clk);
        chk("R5", "rise ignored in fall mode", {16'd0, cc_val}, 32'h0ABC);
        chk("R5", "no flag on ignored edge", {31'd0, flag}, 32'd0);
        #1;
        pin_in = 0; cyc(4);
        @(negedge clk);
        chk("R5", "fall captured", {16'd0, cc_val}, 32'h0BCD);
        #1;
        wr_mode(7'h30);
        tbase = 16'h0CDE; pin_in = 1; cyc(4);
        @(negedge clk);
        chk("R5", "both: rise", {16'd0, cc_val}, 32'h0CDE);
        #1;
        tbase = 16'h0DEF; pin_in = 0; cyc(4);
        @(negedge clk);
        chk("R5", "both: fall", {16'd0, cc_val}, 32'h0DEF);
        #1;

        // R9 capture blocks compare
        cur_req = "R9";
        wr_mode(7'h6C);
        clr_flag();
        p0 = pin_out;
        tbase = 16'h0000; cyc();
        tbase = 16'h0DEF; cyc(5);
        @(negedge clk);
        chk("R9", "no flag on equality", {31'd0, flag}, 32'd0);
        chk("R9", "no toggle on equality", {31'd0, pin_out}, {31'd0, p0});
        #1;
        cyc(2);
        finish_run();
    end
endmodule